// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block chooses which source feeds the RAM supply rail: the main supply or the backup battery. It receives digitized comparator flags from the analog front end and enables exactly one of two power switches. The flags say whether the main supply is above the reset threshold and how battery and supply compare, with a separate flag for each direction of the 40 mV hysteresis window. The battery is chosen only when the main supply has fallen below the reset threshold and the battery sits above the supply by the hysteresis margin. The main supply is taken back either when it climbs above the battery by the margin, or at once when it recovers past the reset threshold.

While the battery feeds the rail, the block reports backup mode. In that mode it forces the power-fail output low and ignores the power-fail comparator. It also holds both reset outputs asserted and withdraws the watchdog enable. Outside backup mode the power-fail output follows the synchronized comparator flag, and the reset outputs follow the request from the reset generator. Every asynchronous comparator flag passes through a synchronizer before it reaches the decision logic, and every path change goes through one cycle in which both switches are open.

Top module: `bbsw_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block comes up with the main switch closed, the battery switch open, backup mode off, the power-fail output low and the watchdog enable high.
- R2: While the synchronized supply-good flag is high, the battery switch stays open, whatever the battery comparison flags report.
- R3: With supply-good low and the battery-above-supply flag low, the main switch stays closed.
- R4: With supply-good low and battery-above-supply high, the main switch opens, and one cycle later the battery switch closes and backup mode turns on.
- R5: In backup, a high supply-above-battery flag opens the battery switch, and one cycle later the main switch closes.
- R6: In backup, supply-good going high starts the return to the main switch even while battery-above-supply is still high.
- R7: The two switch enables are never high together, and every changeover spends exactly one cycle with both low.
- R8: In backup mode the power-fail output is low, whatever the power-fail flag reports.
- R9: Outside backup mode the power-fail output is low when the synchronized power-fail flag reports the input below 1.25 V (flag = 1) and high otherwise.
- R10: In backup mode the active-low reset output is 0, the active-high reset output is 1 and the watchdog enable is 0. Outside backup mode the reset outputs follow `rst_req_i` and the watchdog enable is 1.
- R11: A change on a comparator flag is seen on the two synchronizer stages, and the switch state reacts at the third rising edge after the change. The power-fail output reacts after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_ok_i | input | 1 | Async: main supply above reset threshold |
| batt_above_vcc_i | input | 1 | Async: battery above supply by the margin |
| vcc_above_batt_i | input | 1 | Async: supply above battery by the margin |
| pfi_low_i | input | 1 | Async: power-fail input below 1.25 V |
| rst_req_i | input | 1 | Reset request from the reset pulse generator |
| sw_main_en_o | output | 1 | Close the main-supply switch |
| sw_batt_en_o | output | 1 | Close the battery switch |
| backup_mode_o | output | 1 | Rail is fed from the battery |
| pfo_o | output | 1 | Power-fail output, low on failure or in backup |
| rst_out_n_o | output | 1 | Active-low reset output |
| rst_out_o | output | 1 | Active-high reset output |
| wdog_en_o | output | 1 | Watchdog allowed to count |

## Verification
A wrong path state shows at the switch enables within one cycle of the faulty transition. It appears as a missing or doubled gap cycle, both enables high, or a battery selection that persists after supply-good returns. A synchronizer with the wrong depth shifts every reaction by a whole cycle. A cycle-accurate reference model in the bench exposes that shift on the first flag change. A wrong backup flag is seen the same cycle on the power-fail, reset and watchdog-enable outputs, because all three are gated by it.

// File: rtl/bbsw_pkg.sv
// Package: shared types and constants of the battery switchover controller.
// Assumes: flag vector bit order is fixed by the index constants below.
package bbsw_pkg;

    // Path selection states; the two gap states hold both switches open.
    typedef enum logic [1:0] {
        PATH_MAIN        = 2'b00,
        PATH_GAP_TO_BATT = 2'b01,
        PATH_BATT        = 2'b10,
        PATH_GAP_TO_MAIN = 2'b11
    } path_state_e;

    localparam int unsigned FLAG_COUNT    = 4;
    localparam int unsigned IDX_VCC_OK    = 0;
    localparam int unsigned IDX_BATT_HI   = 1;
    localparam int unsigned IDX_VCC_HI    = 2;
    localparam int unsigned IDX_PFI_LOW   = 3;

    // Reset image of the synchronized flags: power-fail reports failure.
    localparam logic [FLAG_COUNT-1:0] FLAG_RESET_IMAGE = 4'b1000;

endpackage

// File: rtl/bbsw_sync.sv
// Module: multi-bit, multi-stage flop synchronizer for independent level flags.
// Assumes: each bit is a slow level signal, so bits need no mutual coherence.
module bbsw_sync #(
    parameter int unsigned          WIDTH     = 4,
    parameter int unsigned          STAGES    = 2,
    parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Capture the raw asynchronous flags.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            // Shift the flags one stage further toward the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/bbsw_path_fsm.sv
// Module: source selection state machine with break-before-make changeover.
// Assumes: inputs are already synchronized; the supply-good flag dominates.
module bbsw_path_fsm
    import bbsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic batt_hi,
    input  logic vcc_hi,
    output logic sw_main_en,
    output logic sw_batt_en,
    output logic backup_mode
);

    path_state_e state_q, state_d;

    // Next path: enter battery only on a low supply with battery ahead.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PATH_MAIN:        if (!vcc_ok && batt_hi) state_d = PATH_GAP_TO_BATT;
            PATH_GAP_TO_BATT: state_d = vcc_ok ? PATH_MAIN : PATH_BATT;
            PATH_BATT:        if (vcc_ok || vcc_hi) state_d = PATH_GAP_TO_MAIN;
            PATH_GAP_TO_MAIN: state_d = PATH_MAIN;
            default:          state_d = PATH_MAIN;
        endcase
    end

    // State register, main path after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PATH_MAIN;
        else        state_q <= state_d;
    end

    // Decode switch enables straight from the state register.
    always_comb begin
        sw_main_en  = (state_q == PATH_MAIN);
        sw_batt_en  = (state_q == PATH_BATT);
        backup_mode = (state_q == PATH_BATT);
    end

    // R7: the two switches never conduct together.
    p_never_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_main_en && sw_batt_en));

    // R7: the battery switch closes only after a cycle with both open.
    p_batt_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_batt_en) |-> $past(!sw_main_en && !sw_batt_en));

    // R7: the main switch closes only after the battery switch was open.
    p_main_after_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_main_en) |-> $past(!sw_batt_en));

    // R6: supply-good in backup always ends the battery path next cycle.
    p_vcc_ok_leaves_batt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_batt_en && vcc_ok) |=> !sw_batt_en);

    // R3: without the battery ahead the main path holds.
    p_main_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_main_en && !batt_hi) |=> sw_main_en);

endmodule

// File: rtl/bbsw_gate.sv
// Module: backup-mode gating of power-fail, reset and watchdog-enable outputs.
// Assumes: backup_mode comes from a register; pfi_low is synchronized.
module bbsw_gate (
    input  logic backup_mode,
    input  logic pfi_low,
    input  logic rst_req,
    output logic pfo,
    output logic rst_out_n,
    output logic rst_out,
    output logic wdog_en
);

    // Force the supervisory outputs to their backup values when on battery.
    always_comb begin
        pfo       = !backup_mode && !pfi_low;
        rst_out   = backup_mode || rst_req;
        rst_out_n = !rst_out;
        wdog_en   = !backup_mode;
    end

endmodule

// File: rtl/bbsw_ctrl.sv
// Module: top of the battery switchover controller.
// Assumes: comparator flags are asynchronous levels; rst_req_i is already
// in the clk domain. Synchronizer depth is set by SYNC_STAGES.
module bbsw_ctrl
    import bbsw_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok_i,
    input  logic batt_above_vcc_i,
    input  logic vcc_above_batt_i,
    input  logic pfi_low_i,
    input  logic rst_req_i,
    output logic sw_main_en_o,
    output logic sw_batt_en_o,
    output logic backup_mode_o,
    output logic pfo_o,
    output logic rst_out_n_o,
    output logic rst_out_o,
    output logic wdog_en_o
);

    logic [FLAG_COUNT-1:0] flags_async;
    logic [FLAG_COUNT-1:0] flags_sync;

    // Bundle the raw comparator flags in package bit order.
    always_comb begin
        flags_async              = '0;
        flags_async[IDX_VCC_OK]  = vcc_ok_i;
        flags_async[IDX_BATT_HI] = batt_above_vcc_i;
        flags_async[IDX_VCC_HI]  = vcc_above_batt_i;
        flags_async[IDX_PFI_LOW] = pfi_low_i;
    end

    bbsw_sync #(
        .WIDTH     (FLAG_COUNT),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (FLAG_RESET_IMAGE)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_async),
        .sync_o  (flags_sync)
    );

    bbsw_path_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vcc_ok      (flags_sync[IDX_VCC_OK]),
        .batt_hi     (flags_sync[IDX_BATT_HI]),
        .vcc_hi      (flags_sync[IDX_VCC_HI]),
        .sw_main_en  (sw_main_en_o),
        .sw_batt_en  (sw_batt_en_o),
        .backup_mode (backup_mode_o)
    );

    bbsw_gate gate_i (
        .backup_mode (backup_mode_o),
        .pfi_low     (flags_sync[IDX_PFI_LOW]),
        .rst_req     (rst_req_i),
        .pfo         (pfo_o),
        .rst_out_n   (rst_out_n_o),
        .rst_out     (rst_out_o),
        .wdog_en     (wdog_en_o)
    );

    // R8: backup mode never shows a passing power-fail output.
    p_pfo_low_in_backup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        backup_mode_o |-> !pfo_o);

    // R10: backup mode holds both resets asserted and the watchdog off.
    p_reset_in_backup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        backup_mode_o |-> (!rst_out_n_o && rst_out_o && !wdog_en_o));

    // R2: a stable supply-good at the switch stage keeps the battery open.
    p_vcc_ok_no_batt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_sync[IDX_VCC_OK] && !sw_batt_en_o) |=> !sw_batt_en_o);

endmodule

// File: tb/bbsw_ctrl_tb.sv
`timescale 1ns/1ps
module bbsw_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 1'b0, batt_hi = 1'b0, vcc_hi = 1'b0, pfi_low = 1'b0, rst_req = 1'b0;
    logic sw_main, sw_batt, backup, pfo, rst_out_n, rst_out, wdog_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit mon_en = 1'b0;

    always #2 clk = ~clk;

    bbsw_ctrl dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .vcc_ok_i         (vcc_ok),
        .batt_above_vcc_i (batt_hi),
        .vcc_above_batt_i (vcc_hi),
        .pfi_low_i        (pfi_low),
        .rst_req_i        (rst_req),
        .sw_main_en_o     (sw_main),
        .sw_batt_en_o     (sw_batt),
        .backup_mode_o    (backup),
        .pfo_o            (pfo),
        .rst_out_n_o      (rst_out_n),
        .rst_out_o        (rst_out),
        .wdog_en_o        (wdog_en)
    );

    // Reference model from the requirements: two sync stages (R11), path
    // states 0 main, 1 gap to battery, 2 battery, 3 gap to main.
    // Flag bits: 0 supply-good, 1 battery ahead, 2 supply ahead, 3 power-fail low.
    int         m_state = 0;
    logic [3:0] m_s1 = 4'b1000, m_s2 = 4'b1000;

    function automatic int model_next(int st, logic [3:0] f);
        case (st)
            0:       return (!f[0] && f[1]) ? 1 : 0;
            1:       return f[0] ? 0 : 2;
            2:       return (f[0] || f[2]) ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 4'b1000; m_s2 <= 4'b1000; m_state <= 0;
        end else begin
            m_s1    <= {pfi_low, vcc_hi, batt_hi, vcc_ok};
            m_s2    <= m_s1;
            m_state <= model_next(m_state, m_s2);
        end
    end

    task automatic check(string req, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, name, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (mon_en) begin
            logic eb;
            eb = (m_state == 2);
            check("R7", "both_switches", sw_main && sw_batt, 1'b0);
            check(m_s2[0] ? "R2" : "R3", "sw_main", sw_main, m_state == 0);
            check(m_s2[0] ? "R6" : "R4", "sw_batt", sw_batt, eb);
            check("R4", "backup", backup, eb);
            check(eb ? "R8" : "R9", "pfo", pfo, eb ? 1'b0 : !m_s2[3]);
            check("R10", "rst_out", rst_out, eb || rst_req);
            check("R10", "rst_out_n", rst_out_n, !(eb || rst_req));
            check("R10", "wdog_en", wdog_en, !eb);
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic enter_backup();
        vcc_ok = 1'b0; vcc_hi = 1'b0; batt_hi = 1'b1;
        step(5);
        check("R4", "enter_backup", sw_batt, 1'b1);
    endtask

    initial begin
        int hold;
        void'($urandom(32'd4242));
        pfi_low = 1'b1;
        step(3);
        // R1: reset state
        check("R1", "reset_sw_main", sw_main, 1'b1);
        check("R1", "reset_sw_batt", sw_batt, 1'b0);
        check("R1", "reset_backup", backup, 1'b0);
        check("R1", "reset_pfo", pfo, 1'b0);
        check("R1", "reset_wdog_en", wdog_en, 1'b1);
        rst_n = 1'b1; mon_en = 1'b1;

        // R3: supply low, battery not ahead: stays on main
        step(6);
        check("R3", "low_no_batt_main", sw_main, 1'b1);

        // R9: power-fail follows the flag outside backup
        pfi_low = 1'b0; step(3);
        check("R9", "pfo_high", pfo, 1'b1);
        pfi_low = 1'b1; step(3);
        check("R9", "pfo_low", pfo, 1'b0);
        pfi_low = 1'b0; step(3);

        // R11 + R7 + R4: exact changeover timing
        batt_hi = 1'b1;
        step(2);
        check("R11", "main_after_2_edges", sw_main, 1'b1);
        step(1);
        check("R7", "gap_main_off", sw_main, 1'b0);
        check("R7", "gap_batt_off", sw_batt, 1'b0);
        step(1);
        check("R4", "batt_on", sw_batt, 1'b1);
        check("R4", "backup_on", backup, 1'b1);

        // R8 + R10: backup gating
        pfi_low = 1'b0; rst_req = 1'b0; step(4);
        check("R8", "pfo_forced_low", pfo, 1'b0);
        check("R10", "rst_n_low_backup", rst_out_n, 1'b0);
        check("R10", "rst_high_backup", rst_out, 1'b1);
        check("R10", "wdog_off_backup", wdog_en, 1'b0);

        // R5: supply ahead of battery returns through one gap
        batt_hi = 1'b0; vcc_hi = 1'b1;
        step(3);
        check("R5", "gap_before_main", sw_main || sw_batt, 1'b0);
        step(1);
        check("R5", "main_back", sw_main, 1'b1);
        check("R10", "wdog_back", wdog_en, 1'b1);

        // R6: supply-good forces return while battery still ahead
        enter_backup();
        vcc_ok = 1'b1;
        step(5);
        check("R6", "vcc_ok_main", sw_main, 1'b1);
        // R2: stays on main with battery ahead and supply good
        step(10);
        check("R2", "vcc_ok_holds_main", sw_batt, 1'b0);

        // Constrained random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int pick;
            pick = $urandom % 3;
            vcc_ok  = ($urandom % 4) == 0;
            batt_hi = (pick == 0);
            vcc_hi  = (pick == 1);
            pfi_low = $urandom % 2;
            rst_req = ($urandom % 5) == 0;
            hold = 1 + ($urandom % 6);
            step(hold);
        end

        // R1 again: mid-run reset returns to main
        enter_backup();
        mon_en = 1'b0; rst_n = 1'b0; step(2);
        check("R1", "rereset_main", sw_main, 1'b1);
        check("R1", "rereset_backup", backup, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule